// File: doc/BRIEF.md
# Multicycle RISC Core Sequencer

This block is a small 32-bit processor core that runs a four-instruction subset (load word, store word, register-to-register arithmetic and logic, branch on equal) by stepping each instruction through a short series of clock cycles. All arithmetic goes through one ALU. The core keeps an instruction register, two operand latches, an ALU result latch and a load-data latch, along with a 32-entry register file. A separate program-counter incrementer advances the fetch address.

Instructions and data come through two independent memory ports. Reads on both ports are combinational from the address the core presents. Stores take effect at the clock edge on which the write strobe is high. Every instruction class uses only the steps it needs. A branch finishes in three cycles. Arithmetic and store take four. A load takes five. An opcode outside the subset costs two cycles and changes nothing.

Top module: `mcyc_core`

## Requirements
- R1: While reset is held, the fetch address equals the RESET_PC parameter, the instruction read strobe is high and the data write strobe is low. The first cycle after reset is a fetch.
- R2: A fetch cycle latches the instruction word at the current address and advances the fetch address by 4.
- R3: A branch target is the address of the following instruction plus the sign-extended 16-bit immediate (bits 15:0) shifted left by 2. It is formed during decode, so negative offsets branch backwards.
- R4: Cycles from one fetch to the next are 5 for a load, 4 for a store, 4 for an arithmetic instruction, 3 for a branch and 2 for an unknown opcode.
- R5: Opcode 0x00 selects an arithmetic instruction whose funct field (bits 5:0) picks the operation: 0x20 add, 0x22 subtract (wrapping), 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0). The result goes to the register named by bits 15:11. Any other funct value writes no register.
- R6: Opcode 0x23 (load) reads data memory at the register named by bits 25:21 plus the sign-extended immediate. It writes the word read into the register named by bits 20:16.
- R7: Opcode 0x2B (store) writes the register named by bits 20:16 to data memory at base plus the sign-extended immediate. The data write strobe is high for exactly one cycle.
- R8: Opcode 0x04 (branch) compares the registers named by bits 25:21 and 20:16. If they are equal, the next fetch comes from the branch target. Otherwise execution continues in sequence.
- R9: Register 0 always reads as zero. Loads and arithmetic results aimed at it are discarded.
- R10: Any other opcode leaves registers and data memory unchanged and goes back to fetch after decode. The fetch address has advanced only by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_re | output | 1 | Instruction read strobe, high during fetch |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_re | output | 1 | Data read strobe, high in a load's memory cycle |
| dmem_we | output | 1 | Data write strobe, high in a store's memory cycle |
| dmem_addr | output | 32 | Byte address for data access |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Data word at dmem_addr |

## Verification
The bench builds the core with RESET_PC set to 0x40 instead of zero. A design that forgets the reset vector, or treats the vector as a cleared register, then shows up at once in the fetch address. Because the programs sit in the middle of the instruction memory, a backward branch lands on a nonzero address. The target sum therefore exercises sign extension through the upper address bits. Fetch-to-fetch cycle counts are measured at the instruction read strobe for each instruction class, and all other results are read back through stores.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    SB_REG  = 2'd0,
    SB_IMM  = 2'd1,
    SB_BOFF = 2'd2
  } src_b_e;

  typedef struct packed {
    logic    imem_re;
    logic    ir_we;
    logic    pc_inc;
    logic    opnd_we;
    logic    src_a_pc;
    src_b_e  src_b;
    alu_op_e alu_op;
    logic    aluout_we;
    logic    br_check;
    logic    dmem_re;
    logic    mdr_we;
    logic    dmem_we;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] word_offset(input logic [15:0] v);
    logic [XLEN-1:0] s;
    s = sext16(v);
    return {s[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic op_known(input logic [5:0] op);
    return (op == OP_RTYPE) || (op == OP_BEQ) || (op == OP_LW) || (op == OP_SW);
  endfunction

  function automatic logic funct_known(input logic [5:0] f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
           (f == FN_OR)  || (f == FN_SLT);
  endfunction

  function automatic alu_op_e funct_to_op(input logic [5:0] f);
    case (f)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: return a + b;
    endcase
  endfunction

endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile
  import mcyc_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] rd_addr_a,
  output logic [DW-1:0]     rd_data_a,
  input  logic [REG_AW-1:0] rd_addr_b,
  output logic [DW-1:0]     rd_data_b,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data
);

  localparam int NREG = 2 ** REG_AW;

  logic [DW-1:0] regs [NREG];
  logic          wr_fire;

  // Register 0 is never stored; the write is dropped here.
  assign wr_fire = wr_en && (wr_addr != '0);

  always_ff @(posedge clk) begin
    if (wr_fire) regs[wr_addr] <= wr_data;
  end

  assign rd_data_a = (rd_addr_a == '0) ? '0 : regs[rd_addr_a];
  assign rd_data_b = (rd_addr_b == '0) ? '0 : regs[rd_addr_b];

  assert_rf_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (regs[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);

  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output step_e      state,
  output ctl_t       ctl
);

  step_e nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

  always_comb begin
    ctl        = '0;
    ctl.src_b  = SB_REG;
    ctl.alu_op = ALU_ADD;
    nxt        = ST_FETCH;
    case (state)
      ST_FETCH: begin
        ctl.imem_re = 1'b1;
        ctl.ir_we   = 1'b1;
        ctl.pc_inc  = 1'b1;
        nxt         = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.opnd_we   = 1'b1;
        ctl.src_a_pc  = 1'b1;
        ctl.src_b     = SB_BOFF;
        ctl.aluout_we = 1'b1;
        nxt           = op_known(opcode) ? ST_EXEC : ST_FETCH;
      end
      ST_EXEC: begin
        case (opcode)
          OP_LW, OP_SW: begin
            ctl.src_b     = SB_IMM;
            ctl.aluout_we = 1'b1;
            nxt           = ST_MEM;
          end
          OP_RTYPE: begin
            ctl.alu_op    = funct_to_op(funct);
            ctl.aluout_we = 1'b1;
            nxt           = ST_MEM;
          end
          OP_BEQ: begin
            ctl.alu_op   = ALU_SUB;
            ctl.br_check = 1'b1;
            nxt          = ST_FETCH;
          end
          default: nxt = ST_FETCH;
        endcase
      end
      ST_MEM: begin
        case (opcode)
          OP_LW: begin
            ctl.dmem_re = 1'b1;
            ctl.mdr_we  = 1'b1;
            nxt         = ST_WB;
          end
          OP_SW: ctl.dmem_we = 1'b1;
          OP_RTYPE: begin
            ctl.rf_we     = funct_known(funct);
            ctl.rf_dst_rd = 1'b1;
          end
          default: nxt = ST_FETCH;
        endcase
      end
      ST_WB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mdr = 1'b1;
      end
      default: nxt = ST_FETCH;
    endcase
  end

  assert_fetch_then_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  assert_wb_after_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB) |-> ($past(state) == ST_MEM));

  assert_exec_after_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |-> ($past(state) == ST_DECODE));

endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        imem_re,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic        dmem_re,
  output logic        dmem_we,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata
);

  localparam int DW = XLEN;

  logic [DW-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;

  logic [5:0]        op_f, funct_f;
  logic [REG_AW-1:0] rs_f, rt_f, rd_f;
  logic [15:0]       imm_f;
  logic [DW-1:0]     imm_x, boff_x;

  step_e state;
  ctl_t  ctl;

  logic [DW-1:0] rf_a, rf_b, rf_wdata;
  logic [REG_AW-1:0] rf_waddr;
  logic [DW-1:0] alu_a, alu_b, alu_y;
  logic          alu_zero;

  // Named events used by the assertions below.
  logic branch_taken;
  logic decode_unknown;

  assign op_f    = ir_q[31:26];
  assign rs_f    = ir_q[25:21];
  assign rt_f    = ir_q[20:16];
  assign rd_f    = ir_q[15:11];
  assign imm_f   = ir_q[15:0];
  assign funct_f = ir_q[5:0];
  assign imm_x   = sext16(imm_f);
  assign boff_x  = word_offset(imm_f);

  mcyc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (op_f),
    .funct  (funct_f),
    .state  (state),
    .ctl    (ctl)
  );

  assign rf_waddr = ctl.rf_dst_rd ? rd_f : rt_f;
  assign rf_wdata = ctl.rf_from_mdr ? mdr_q : aluout_q;

  mcyc_regfile #(.DW(DW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (rs_f),
    .rd_data_a (rf_a),
    .rd_addr_b (rt_f),
    .rd_data_b (rf_b),
    .wr_en     (ctl.rf_we),
    .wr_addr   (rf_waddr),
    .wr_data   (rf_wdata)
  );

  assign alu_a = ctl.src_a_pc ? pc_q : a_q;

  always_comb begin
    case (ctl.src_b)
      SB_IMM:  alu_b = imm_x;
      SB_BOFF: alu_b = boff_x;
      default: alu_b = b_q;
    endcase
  end

  mcyc_alu #(.DW(DW)) u_alu (
    .op   (ctl.alu_op),
    .a    (alu_a),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign branch_taken   = ctl.br_check && alu_zero;
  assign decode_unknown = (state == ST_DECODE) && !op_known(op_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (ctl.ir_we)       ir_q <= imem_rdata;
      if (ctl.pc_inc)      pc_q <= pc_q + 32'd4;
      else if (branch_taken) pc_q <= aluout_q;
      if (ctl.opnd_we) begin
        a_q <= rf_a;
        b_q <= rf_b;
      end
      if (ctl.aluout_we)   aluout_q <= alu_y;
      if (ctl.mdr_we)      mdr_q <= dmem_rdata;
    end
  end

  assign imem_re    = ctl.imem_re;
  assign imem_addr  = pc_q;
  assign dmem_re    = ctl.dmem_re;
  assign dmem_we    = ctl.dmem_we;
  assign dmem_addr  = aluout_q;
  assign dmem_wdata = b_q;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_re |=> (imem_addr == $past(imem_addr) + 32'd4));

  assert_branch_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> (imem_addr == $past(aluout_q)));

  assert_store_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we);

  assert_unknown_op_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    decode_unknown |=> (state == ST_FETCH && $stable(imem_addr)));

  assert_no_write_outside_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (state == ST_MEM && !dmem_re));

endmodule

// File: tb/mcyc_core_test.sv
module mcyc_core_test;

  localparam logic [31:0] BASE = 32'h0000_0040;
  localparam int BI = 16;

  // {a, b, funct, expected}
  localparam logic [127:0] VEC [8] = '{
    {32'd5,         32'd7,         32'h20, 32'd12},
    {32'd3,         32'd10,        32'h22, 32'hFFFF_FFF9},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 32'h24, 32'hF000_F000},
    {32'hF0F0_F0F0, 32'h0F0F_0000, 32'h25, 32'hFFFF_F0F0},
    {32'hFFFF_FFFF, 32'd1,         32'h2A, 32'd1},
    {32'd5,         32'd2,         32'h2A, 32'd0},
    {32'h8000_0000, 32'h7FFF_FFFF, 32'h2A, 32'd1},
    {32'h8000_0000, 32'd1,         32'h22, 32'h7FFF_FFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        imem_re, dmem_re, dmem_we;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;

  always #10 clk = ~clk;

  mcyc_core #(.RESET_PC(BASE)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_re    (imem_re),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  always @(negedge clk) begin
    if (rst_n && dmem_we) wr_cnt++;
  end

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'hFC00_0000;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic gap_to_fetch(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!imem_re);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int gap;
    int exp_gap [6];
    exp_gap = '{5, 4, 4, 3, 2, 3};

    // Directed program covering every class and the corner cases.
    clear_mem();
    imem[BI+0]  = enc_i(8'h23, 0, 1, 0);     // lw r1,0
    imem[BI+1]  = enc_i(8'h2B, 0, 1, 16);    // sw r1,16
    imem[BI+2]  = enc_r(1, 1, 2, 8'h20);     // add r2=r1+r1
    imem[BI+3]  = enc_i(8'h04, 1, 0, 5);     // beq r1,r0 (not taken)
    imem[BI+4]  = {6'h3F, 5'd0, 5'd1, 16'h0000}; // unknown opcode
    imem[BI+5]  = enc_i(8'h04, 2, 2, 1);     // beq taken, skip next
    imem[BI+6]  = enc_i(8'h2B, 0, 1, 20);    // skipped store
    imem[BI+7]  = enc_i(8'h23, 0, 0, 4);     // lw r0 (discarded)
    imem[BI+8]  = enc_i(8'h2B, 0, 0, 24);    // sw r0,24
    imem[BI+9]  = enc_i(8'h23, 0, 4, 8);     // lw r4,8
    imem[BI+10] = enc_r(1, 1, 4, 8'h3F);     // unknown funct to r4
    imem[BI+11] = enc_i(8'h2B, 0, 4, 28);    // sw r4,28
    imem[BI+12] = enc_i(8'h2B, 0, 2, 32);    // sw r2,32
    imem[BI+13] = enc_i(8'h2B, 0, 1, 36);    // sw r1,36
    imem[BI+14] = enc_i(8'h04, 0, 0, 16'hFFFF); // spin on self
    dmem[0] = 32'h1111_1111;
    dmem[1] = 32'h2222_2222;
    dmem[2] = 32'h0000_ABCD;
    dmem[5] = 32'hDEAD_BEEF;
    dmem[6] = 32'h0000_0055;

    hold_reset();
    chk("R1 reset fetch address", imem_addr, BASE);
    chk("R1 reset read strobe", {31'd0, imem_re}, 32'd1);
    chk("R1 reset write strobe", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    wr_cnt = 0;

    for (int k = 0; k < 6; k++) begin
      gap_to_fetch(gap);
      chk($sformatf("R4 cycles for instruction %0d", k), gap, exp_gap[k]);
      if (k < 5)
        chk("R2 sequential fetch address", imem_addr, BASE + 32'(4 * (k + 1)));
      else
        chk("R8 taken branch target", imem_addr, BASE + 32'd28);
    end

    repeat (80) @(negedge clk);
    chk("R7 store of loaded word", dmem[4], 32'h1111_1111);
    chk("R8 skipped store left memory", dmem[5], 32'hDEAD_BEEF);
    chk("R9 register 0 stays zero", dmem[6], 32'h0);
    chk("R5 unknown funct writes nothing", dmem[7], 32'h0000_ABCD);
    chk("R5 add result", dmem[8], 32'h2222_2222);
    chk("R10 unknown opcode kept r1", dmem[9], 32'h1111_1111);
    chk("R7 write strobe count", wr_cnt, 32'd5);

    gap_to_fetch(gap);
    chk("R3 backward branch target", imem_addr, BASE + 32'd56);
    gap_to_fetch(gap);
    chk("R3 backward branch repeats", imem_addr, BASE + 32'd56);

    // Table-driven arithmetic vectors through load, operate, store.
    for (int v = 0; v < 8; v++) begin
      clear_mem();
      imem[BI+0] = enc_i(8'h23, 0, 1, 0);
      imem[BI+1] = enc_i(8'h23, 0, 2, 4);
      imem[BI+2] = enc_r(1, 2, 3, int'(VEC[v][63:32]));
      imem[BI+3] = enc_i(8'h2B, 0, 3, 8);
      imem[BI+4] = enc_i(8'h04, 0, 0, 16'hFFFF);
      dmem[0] = VEC[v][127:96];
      dmem[1] = VEC[v][95:64];
      hold_reset();
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      chk($sformatf("R5 R6 vector %0d", v), dmem[2], VEC[v][31:0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule